// File: doc/BRIEF.md
# Two-Level Local History Branch Predictor

This block guesses the direction of a conditional branch from that branch's own recent behaviour. A first table keeps a short shift register of outcomes for each branch slot. The slot is chosen by a field of the branch address. The value in that shift register then selects one 2-bit saturating counter in a second table. The upper bit of that counter is the guess. Neither table stores tags, so any two branches whose address field matches share a history slot.

A fetch stage presents a branch address on the lookup port and reads the guess in the same cycle. Both table reads are combinational and run one after the other. When the branch resolves, the execute stage presents the address and the real outcome on the update port. At the next clock edge the block moves the counter that was used one step and shifts the outcome into the branch's history.

Each counter is a four-state machine (`lhp_pkg::ctr_state_e`):
- States: `CTR_STRONG_NT` (00), `CTR_WEAK_NT` (01), `CTR_WEAK_T` (10) and `CTR_STRONG_T` (11).
- A taken outcome moves a counter one state up: STRONG_NT→WEAK_NT→WEAK_T→STRONG_T. STRONG_T stays STRONG_T.
- A not-taken outcome moves a counter one state down along the same chain. STRONG_NT stays STRONG_NT.
- Reset puts every counter in WEAK_NT.

Top module: `lhp_local_predictor`

## Requirements
- R1: The history slot is selected by address bits `pc[PC_LSB +: IDX_W]`, which by default is bits [5:2]. The address bits below that field have no effect on the lookup.
- R2: `pred_taken` is bit 1 of the counter whose index equals the history value stored for `pred_pc`, where 1 means taken. It is valid in the same cycle as `pred_pc`.
- R3: The reset is synchronous and active low. After reset every history is all zeros and every counter is in WEAK_NT (01), so every address predicts not taken.
- R4: An update shifts `upd_taken` into the LSB of the history slot of `upd_pc` and drops the oldest bit. A history holds `HIST_LEN` outcomes (4 by default).
- R5: An update moves the counter selected by the history value from before the shift. A taken outcome moves it one state up and a not-taken outcome moves it one state down.
- R6: A counter saturates. A taken outcome leaves STRONG_T (11) unchanged and a not-taken outcome leaves STRONG_NT (00) unchanged.
- R7: When a lookup and an update touch the same entries in the same cycle, the lookup returns the value from before the update. The new state becomes visible one cycle later.
- R8: While `upd_valid` is low, no history and no counter changes, whatever `upd_pc` and `upd_taken` carry.
- R9: Addresses that differ only in bits outside the index field alias. An update through one of them changes the prediction seen through the other.
- R10: A counter in STRONG_T that sees one not-taken outcome still predicts taken, because WEAK_T has bit 1 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | PC_W | Branch address to predict |
| pred_taken | output | 1 | Guess for `pred_pc`, 1 = taken |
| upd_valid | input | 1 | An update is present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The hardest case to reach is a counter at either end of its range. Every update also changes the history that selects the next counter, so one branch keeps landing on different counters. The stimulus handles this in two steps:
- It drives one branch with a long run of identical outcomes until its history settles at all ones (or all zeros). After that, each further update lands on the same counter and drives it into saturation.
- It then trains a second, unrelated branch to the same history value and reads the saturated counter through that second branch. This shows that a wrapping counter would give a different guess.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

    // Four-state direction counter; bit 1 is the predicted direction.
    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WEAK_NT;

endpackage

// File: rtl/lhp_ctr_step.sv
// Next-state logic of one direction counter.
module lhp_ctr_step
    import lhp_pkg::*;
(
    input  ctr_state_e cur,
    input  logic       taken,
    output ctr_state_e nxt
);

    always_comb begin
        unique case (cur)
            CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
            default:       nxt = CTR_RESET;
        endcase
    end

endmodule

// File: rtl/lhp_hist_table.sv
// Per-branch outcome shift registers, one lookup port and one update port.
module lhp_hist_table #(
    parameter int IDX_W    = 4,
    parameter int HIST_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [HIST_LEN-1:0] rd_hist,
    input  logic                up_we,
    input  logic [IDX_W-1:0]    up_idx,
    input  logic                up_taken,
    output logic [HIST_LEN-1:0] up_hist
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0][HIST_LEN-1:0] hist_q;
    logic [HIST_LEN-1:0]              hist_shifted;

    assign rd_hist = hist_q[rd_idx];
    assign up_hist = hist_q[up_idx];

    generate
        if (HIST_LEN == 1) begin : g_single
            assign hist_shifted = up_taken;
        end else begin : g_shift
            assign hist_shifted = {up_hist[HIST_LEN-2:0], up_taken};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (up_we) begin
            hist_q[up_idx] <= hist_shifted;
        end
    end

    // R4
    hist_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_we |=> hist_q[$past(up_idx)][0] == $past(up_taken));

    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_we |=> $stable(hist_q));

    // R3
    hist_reset_chk: assert property (@(posedge clk)
        !rst_n |=> hist_q == '0);

endmodule

// File: rtl/lhp_pattern_table.sv
// Direction counters indexed by a history value.
module lhp_pattern_table
    import lhp_pkg::*;
#(
    parameter int HIST_LEN = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HIST_LEN-1:0] rd_hist,
    output ctr_state_e          rd_ctr,
    input  logic                up_we,
    input  logic [HIST_LEN-1:0] up_hist,
    input  logic                up_taken
);

    localparam int CTRS = 1 << HIST_LEN;

    ctr_state_e [CTRS-1:0] ctr_q;
    ctr_state_e            up_ctr;
    ctr_state_e            up_next;

    assign rd_ctr = ctr_q[rd_hist];
    assign up_ctr = ctr_q[up_hist];

    lhp_ctr_step u_step (
        .cur   (up_ctr),
        .taken (up_taken),
        .nxt   (up_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CTRS; i++) begin
                ctr_q[i] <= CTR_RESET;
            end
        end else if (up_we) begin
            ctr_q[up_hist] <= up_next;
        end
    end

    // R6
    ctr_sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_we && up_taken && up_ctr == CTR_STRONG_T)
        |=> ctr_q[$past(up_hist)] == CTR_STRONG_T);

    // R6
    ctr_sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_we && !up_taken && up_ctr == CTR_STRONG_NT)
        |=> ctr_q[$past(up_hist)] == CTR_STRONG_NT);

    // R5
    ctr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_we && up_taken && up_ctr != CTR_STRONG_T)
        |=> 2'(ctr_q[$past(up_hist)]) == 2'(2'($past(up_ctr)) + 2'd1));

    // R5
    ctr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_we && !up_taken && up_ctr != CTR_STRONG_NT)
        |=> 2'(ctr_q[$past(up_hist)]) == 2'(2'($past(up_ctr)) - 2'd1));

    // R8
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_we |=> $stable(ctr_q));

    // R3
    ctr_reset_chk: assert property (@(posedge clk)
        !rst_n |=> ctr_q[0] == CTR_WEAK_NT);

endmodule

// File: rtl/lhp_local_predictor.sv
// Two-level local history direction predictor.
module lhp_local_predictor
    import lhp_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int PC_LSB   = 2,
    parameter int IDX_W    = 4,
    parameter int HIST_LEN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    logic [IDX_W-1:0]    pred_idx;
    logic [IDX_W-1:0]    upd_idx;
    logic [HIST_LEN-1:0] pred_hist;
    logic [HIST_LEN-1:0] upd_hist;
    ctr_state_e          pred_ctr;
    logic [1:0]          pred_bits;

    // First level: the address field picks a history slot.
    assign pred_idx = pred_pc[PC_LSB +: IDX_W];
    assign upd_idx  = upd_pc[PC_LSB +: IDX_W];

    lhp_hist_table #(
        .IDX_W    (IDX_W),
        .HIST_LEN (HIST_LEN)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_hist  (pred_hist),
        .up_we    (upd_valid),
        .up_idx   (upd_idx),
        .up_taken (upd_taken),
        .up_hist  (upd_hist)
    );

    // Second level: the history value picks a counter.
    lhp_pattern_table #(
        .HIST_LEN (HIST_LEN)
    ) u_pat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_hist  (pred_hist),
        .rd_ctr   (pred_ctr),
        .up_we    (upd_valid),
        .up_hist  (upd_hist),
        .up_taken (upd_taken)
    );

    assign pred_bits  = pred_ctr;
    assign pred_taken = pred_bits[1];

    // R8
    pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> (!$stable(pred_pc) || $stable(pred_taken)));

    // R5
    upd_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> !$isunknown({upd_pc, upd_taken}));

endmodule

// File: tb/lhp_local_predictor_test.sv
`timescale 1ns/1ps
module lhp_local_predictor_test;

    localparam int PC_W   = 32;
    localparam int PC_LSB = 2;
    localparam int IDX_W  = 4;
    localparam int HL     = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] pred_pc = '0;
    logic            pred_taken;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;

    always #2.5 clk = ~clk;

    lhp_local_predictor #(
        .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .HIST_LEN(HL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
    );

    typedef struct {
        logic            exp;
        logic [PC_W-1:0] pc;
        string           tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;

    // Reference state built from the requirements.
    logic [HL-1:0] m_hist [1<<IDX_W];
    logic [1:0]    m_ctr  [1<<HL];

    function automatic int slot(input logic [PC_W-1:0] pc);
        return int'(pc[PC_LSB +: IDX_W]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < (1<<IDX_W); i++) m_hist[i] = '0;
        for (int i = 0; i < (1<<HL); i++)    m_ctr[i]  = 2'b01;
    endtask

    // Driver: one cycle of stimulus, optionally queueing an expected guess.
    task automatic step(input logic [PC_W-1:0] ppc, input logic uv,
                        input logic [PC_W-1:0] upc, input logic ut,
                        input string tag, input bit chk);
        logic [HL-1:0] h;
        logic [1:0]    c;
        item_t         it;
        @(negedge clk);
        pred_pc   = ppc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        if (chk) begin
            it.exp = m_ctr[m_hist[slot(ppc)]][1];
            it.pc  = ppc;
            it.tag = tag;
            q.push_back(it);
        end
        if (uv) begin
            h = m_hist[slot(upc)];
            c = m_ctr[h];
            if (ut && c != 2'b11) c = c + 2'b01;
            else if (!ut && c != 2'b00) c = c - 2'b01;
            m_ctr[h] = c;
            m_hist[slot(upc)] = {h[HL-2:0], ut};
        end
    endtask

    task automatic pred(input logic [PC_W-1:0] pc, input string tag);
        step(pc, 1'b0, '0, 1'b0, tag, 1'b1);
    endtask

    task automatic upd(input logic [PC_W-1:0] pc, input logic t);
        step(32'h0, 1'b1, pc, t, "", 1'b0);
    endtask

    // Monitor: compares queued expectations before the next rising edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1.5;
            while (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (pred_taken !== it.exp) begin
                    failures++;
                    $display("FAIL %s pc=%h actual=%b expected=%b",
                             it.tag, it.pc, pred_taken, it.exp);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam logic [PC_W-1:0] PA = 32'h0000_0010;
    localparam logic [PC_W-1:0] PB = 32'h0000_0020;
    localparam logic [PC_W-1:0] PC = 32'h0000_0030;
    localparam logic [PC_W-1:0] PD = 32'h0000_0034;
    localparam logic [PC_W-1:0] PF = 32'h0000_0008;
    localparam logic [PC_W-1:0] PG = 32'h0000_000C;

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) step('0, 1'b0, '0, 1'b0, "", 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: everything predicts not taken after reset
        pred(32'h0, "R3");
        pred(PA, "R3");
        pred(PB, "R3");
        pred(32'hFFFF_FFFC, "R3");

        // R2: the counter is chosen by history, so B sees A's training
        upd(PA, 1'b1);
        pred(PB, "R2");
        // R4: A's history moved to 0001, selecting a different counter
        pred(PA, "R4");

        // R7: same-cycle lookup and update of B sees the old state
        step(PB, 1'b1, PB, 1'b0, "R7", 1'b1);
        pred(PB, "R7");

        // R8: update inputs without upd_valid change nothing
        step(PB, 1'b0, PB, 1'b1, "R8", 1'b1);
        step(PB, 1'b0, PB, 1'b1, "R8", 1'b1);
        step(PA, 1'b0, PA, 1'b0, "R8", 1'b1);
        pred(PB, "R8");

        // R6 / R10: saturate counter 1111, then one not-taken step
        repeat (8) upd(PC, 1'b1);
        upd(PC, 1'b0);
        repeat (4) upd(PD, 1'b1);
        pred(PD, "R6/R10");
        // R1: bits below the index field are ignored
        pred(PD | 32'h3, "R1");

        // R6: saturate counter 0000 low, then one taken step
        repeat (5) upd(PF, 1'b0);
        upd(PF, 1'b1);
        pred(PG, "R6");
        upd(PG, 1'b1);
        pred(32'h0000_001C, "R5");

        // R9: aliases through the upper address bits
        repeat (4) upd(PA + 32'h40, 1'b1);
        pred(PA, "R9");
        pred(PA | 32'h1000_0000, "R9");
        upd(32'h8000_0010, 1'b0);
        pred(PA, "R9");

        // R5: mixed traffic over all slots
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step({24'h0, lfsr[7:0]}, lfsr[9] | lfsr[3], {24'h0, lfsr[15:8]},
                 lfsr[11] | lfsr[2], "R5", 1'b1);
        end

        step('0, 1'b0, '0, 1'b0, "", 1'b0);
        @(negedge clk);
        #2;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule